// File: doc/BRIEF.md
# Prescaled 64-bit Machine Timer

This block is a free-running 64-bit time base for a single processor core, with a set of compare channels that raise interrupts. A prescaler divides the clock into ticks. On every tick the counter advances by a programmable step rather than by one, so software can match the count rate to a wall-clock unit without extra dividers. Each compare channel holds a 64-bit limit. A channel expires once the counter has reached or passed that limit. Expiry latches a sticky status bit, and that bit drives the channel's interrupt line when the channel is enabled.

Software reaches every register through a plain 32-bit register port with a 12-bit byte address. Each 64-bit quantity is split into a lower word and an upper word. Writes take effect at the clock edge that samples them. Read data is registered and appears one cycle after the read request. A test register lets software force status bits, which exercises the interrupt wiring without moving time.

Top module: `mtimer_core`

## Requirements
- R1: A config register at 0x10C holds the prescale in bits 11:0 and the step in bits 23:16. The step resets to 1 and the prescale resets to 0. While counting, a tick occurs on every (prescale+1)-th active clock edge. A prescale of 0 gives a tick on every active edge.
- R2: On each tick the 64-bit counter adds the step. A carry moves from the lower word into the upper word.
- R3: Bit 0 of the control register at 0x000 turns counting on. While it is 0, the counter and the prescaler do not advance.
- R4: The counter reads and writes as a lower word at 0x110 and an upper word at 0x114. A software write to either word wins over a tick in the same cycle.
- R5: Channel j has its compare lower word at 0x118+8j and its upper word at 0x11C+8j. Both words reset to 0xFFFFFFFF.
- R6: When the counter is greater than or equal to channel j's compare value, status bit j is set at the next edge. It is set again on every cycle while that condition holds.
- R7: The status register at 0x104 clears bit j when software writes 1 to bit j. The clear does not hold while channel j is still expired.
- R8: The enable register at 0x100 gates status bit j onto irq[j].
- R9: Writing 1 to bit j of the test register at 0x108 sets status bit j. A read of the test register returns 0.
- R10: Read data appears on the cycle after the read request. Unmapped offsets read as 0. The read data is 0 in any cycle that follows no read.
- R11: After reset the control, enable and status registers are 0, the counter is 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | NUM_TIMERS | Per-channel interrupt, status AND enable |

## Verification
Counting is checked over windows of exactly k active edges. The window opens with the edge that writes the enable bit and closes with the edge that clears it, so the expected value is step times floor(k/(prescale+1)). Read data is sampled one cycle after the read request. Any change to the counter or a compare word leaves one idle cycle before status or irq is observed: expiry is computed in the cycle after the write, and status latches one edge after that. Test-register writes and status clears land at their own write edge, so they are read back at once.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
   localparam int unsigned ADDR_W = 12;
   localparam int unsigned DATA_W = 32;

   localparam logic [ADDR_W-1:0] OFF_CTRL     = 12'h000;
   localparam logic [ADDR_W-1:0] OFF_ENABLE   = 12'h100;
   localparam logic [ADDR_W-1:0] OFF_STATUS   = 12'h104;
   localparam logic [ADDR_W-1:0] OFF_TEST     = 12'h108;
   localparam logic [ADDR_W-1:0] OFF_CFG      = 12'h10C;
   localparam logic [ADDR_W-1:0] OFF_CNT_LO   = 12'h110;
   localparam logic [ADDR_W-1:0] OFF_CNT_HI   = 12'h114;
   localparam logic [ADDR_W-1:0] OFF_CMP_BASE = 12'h118;
   localparam int unsigned       CMP_STRIDE   = 8;

   localparam int unsigned CFG_PRE_LSB  = 0;
   localparam int unsigned CFG_STEP_LSB = 16;

   function automatic logic [ADDR_W-1:0] cmp_addr(input int unsigned idx, input logic upper);
      return OFF_CMP_BASE + ADDR_W'(idx * CMP_STRIDE) + (upper ? ADDR_W'(4) : ADDR_W'(0));
   endfunction
endpackage

// File: rtl/mtimer_prescaler.sv
module mtimer_prescaler #(
   parameter int unsigned PRESCALE_W = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic [PRESCALE_W-1:0] limit,
   output logic                  tick
);
   logic [PRESCALE_W-1:0] div_q;

   assign tick = en && (div_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (!en)    div_q <= '0;
      else if (tick)   div_q <= '0;
      else             div_q <= div_q + PRESCALE_W'(1);
   end
endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter
   import mtimer_pkg::*;
#(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [STEP_W-1:0] step,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  value
);
   localparam int unsigned HI_W = CNT_W - DATA_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (wr_lo || wr_hi) begin
         if (wr_lo) value[DATA_W-1:0]     <= wdata;
         if (wr_hi) value[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      end else if (tick) begin
         value <= value + CNT_W'(step);
      end
   end
endmodule

// File: rtl/mtimer_compare.sv
module mtimer_compare
   import mtimer_pkg::*;
#(
   parameter int unsigned CNT_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  now,
   output logic [CNT_W-1:0]  limit,
   output logic              expired
);
   localparam int unsigned HI_W = CNT_W - DATA_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit <= '1;
      end else begin
         if (wr_lo) limit[DATA_W-1:0]     <= wdata;
         if (wr_hi) limit[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      end
   end

   assign expired = (now >= limit);
endmodule

// File: rtl/mtimer_core.sv
module mtimer_core
   import mtimer_pkg::*;
#(
   parameter int unsigned NUM_TIMERS = 2,
   parameter int unsigned PRESCALE_W = 12,
   parameter int unsigned STEP_W     = 8,
   parameter int unsigned CNT_W      = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_req,
   input  logic                  reg_we,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic [NUM_TIMERS-1:0] irq
);
   localparam int unsigned HI_W = CNT_W - DATA_W;

   if (NUM_TIMERS < 1 || NUM_TIMERS > 8) begin : g_bad_timers
      $error("NUM_TIMERS must be 1..8");
   end
   if (PRESCALE_W < 1 || PRESCALE_W > CFG_STEP_LSB) begin : g_bad_pre
      $error("PRESCALE_W must fit below the step field");
   end
   if (STEP_W < 1 || STEP_W > 8) begin : g_bad_step
      $error("STEP_W must be 1..8");
   end
   if (CNT_W <= DATA_W || CNT_W > 2 * DATA_W) begin : g_bad_cnt
      $error("CNT_W must be 33..64");
   end

   // register decode
   logic wr_en, hit_ctrl, hit_ie, hit_is, hit_it, hit_cfg, hit_cnt_lo, hit_cnt_hi, cnt_wr;
   assign wr_en      = reg_req && reg_we;
   assign hit_ctrl   = wr_en && (reg_addr == OFF_CTRL);
   assign hit_ie     = wr_en && (reg_addr == OFF_ENABLE);
   assign hit_is     = wr_en && (reg_addr == OFF_STATUS);
   assign hit_it     = wr_en && (reg_addr == OFF_TEST);
   assign hit_cfg    = wr_en && (reg_addr == OFF_CFG);
   assign hit_cnt_lo = wr_en && (reg_addr == OFF_CNT_LO);
   assign hit_cnt_hi = wr_en && (reg_addr == OFF_CNT_HI);
   assign cnt_wr     = hit_cnt_lo || hit_cnt_hi;

   // control and configuration
   logic                  active_q;
   logic [PRESCALE_W-1:0] prescale_q;
   logic [STEP_W-1:0]     step_q;
   logic [NUM_TIMERS-1:0] ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         prescale_q <= '0;
         step_q     <= STEP_W'(1);
         ie_q       <= '0;
      end else begin
         if (hit_ctrl) active_q <= reg_wdata[0];
         if (hit_cfg) begin
            prescale_q <= reg_wdata[CFG_PRE_LSB +: PRESCALE_W];
            step_q     <= reg_wdata[CFG_STEP_LSB +: STEP_W];
         end
         if (hit_ie) ie_q <= reg_wdata[NUM_TIMERS-1:0];
      end
   end

   // time base
   logic             tick;
   logic [CNT_W-1:0] cnt_q;

   mtimer_prescaler #(.PRESCALE_W(PRESCALE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (active_q),
      .limit (prescale_q),
      .tick  (tick)
   );

   mtimer_counter #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .step  (step_q),
      .wr_lo (hit_cnt_lo),
      .wr_hi (hit_cnt_hi),
      .wdata (reg_wdata),
      .value (cnt_q)
   );

   // compare channels
   logic [NUM_TIMERS-1:0] expired;
   logic [CNT_W-1:0]      cmp_q [NUM_TIMERS];

   for (genvar j = 0; j < NUM_TIMERS; j++) begin : g_ch
      logic wr_lo_j, wr_hi_j;
      assign wr_lo_j = wr_en && (reg_addr == cmp_addr(j, 1'b0));
      assign wr_hi_j = wr_en && (reg_addr == cmp_addr(j, 1'b1));

      mtimer_compare #(.CNT_W(CNT_W)) u_cmp (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_lo   (wr_lo_j),
         .wr_hi   (wr_hi_j),
         .wdata   (reg_wdata),
         .now     (cnt_q),
         .limit   (cmp_q[j]),
         .expired (expired[j])
      );
   end

   // sticky status: hardware set and test set win over software clear
   logic [NUM_TIMERS-1:0] is_q, clr_mask, set_mask;
   assign clr_mask = hit_is ? reg_wdata[NUM_TIMERS-1:0] : '0;
   assign set_mask = expired | (hit_it ? reg_wdata[NUM_TIMERS-1:0] : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) is_q <= '0;
      else        is_q <= (is_q & ~clr_mask) | set_mask;
   end

   assign irq = is_q & ie_q;

   // read path
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      case (reg_addr)
         OFF_CTRL:   rd_mux[0] = active_q;
         OFF_ENABLE: rd_mux[NUM_TIMERS-1:0] = ie_q;
         OFF_STATUS: rd_mux[NUM_TIMERS-1:0] = is_q;
         OFF_CFG: begin
            rd_mux[CFG_PRE_LSB +: PRESCALE_W] = prescale_q;
            rd_mux[CFG_STEP_LSB +: STEP_W]    = step_q;
         end
         OFF_CNT_LO: rd_mux = cnt_q[DATA_W-1:0];
         OFF_CNT_HI: rd_mux[HI_W-1:0] = cnt_q[CNT_W-1:DATA_W];
         default: ;
      endcase
      for (int j = 0; j < NUM_TIMERS; j++) begin
         if (reg_addr == cmp_addr(j, 1'b0)) rd_mux = cmp_q[j][DATA_W-1:0];
         if (reg_addr == cmp_addr(j, 1'b1)) rd_mux = DATA_W'(cmp_q[j][CNT_W-1:DATA_W]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 reg_rdata <= '0;
      else if (reg_req && !reg_we) reg_rdata <= rd_mux;
      else                        reg_rdata <= '0;
   end
endmodule

// File: rtl/mtimer_core_chk.sv
module mtimer_core_chk
   import mtimer_pkg::*;
#(
   parameter int unsigned NUM_TIMERS = 2,
   parameter int unsigned PRESCALE_W = 12,
   parameter int unsigned STEP_W     = 8,
   parameter int unsigned CNT_W      = 64
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  active_q,
   input logic                  tick,
   input logic [PRESCALE_W-1:0] prescale_q,
   input logic [STEP_W-1:0]     step_q,
   input logic [CNT_W-1:0]      cnt_q,
   input logic                  cnt_wr,
   input logic                  hit_cfg,
   input logic                  hit_is,
   input logic                  hit_it,
   input logic [DATA_W-1:0]     wdata,
   input logic [NUM_TIMERS-1:0] expired,
   input logic [NUM_TIMERS-1:0] is_q
);
   // R1: a nonzero prescale never yields two ticks in a row
   a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && prescale_q != '0 && !hit_cfg) |=> !tick);

   // R2: a tick without a software write adds the step
   a_r2_step_add: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'($past(step_q))));

   // R3: inactive and unwritten counter holds
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !cnt_wr) |=> $stable(cnt_q));

   for (genvar j = 0; j < NUM_TIMERS; j++) begin : g_chk
      // R6: expiry sets the status bit at the next edge
      a_r6_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
         expired[j] |=> is_q[j]);

      // R7: a status bit only falls after a software clear of that bit
      a_r7_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(is_q[j]) |-> $past(hit_is && wdata[j]));

      // R9: a test write sets the status bit
      a_r9_test_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_it && wdata[j]) |=> is_q[j]);
   end
endmodule

bind mtimer_core mtimer_core_chk #(
   .NUM_TIMERS (NUM_TIMERS),
   .PRESCALE_W (PRESCALE_W),
   .STEP_W     (STEP_W),
   .CNT_W      (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .active_q   (active_q),
   .tick       (tick),
   .prescale_q (prescale_q),
   .step_q     (step_q),
   .cnt_q      (cnt_q),
   .cnt_wr     (cnt_wr),
   .hit_cfg    (hit_cfg),
   .hit_is     (hit_is),
   .hit_it     (hit_it),
   .wdata      (reg_wdata),
   .expired    (expired),
   .is_q       (is_q)
);

// File: tb/tb_mtimer_core.sv
`timescale 1ns/1ps
module tb_mtimer_core;
   localparam int NT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_req = 1'b0;
   logic          reg_we = 1'b0;
   logic [11:0]   reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NT-1:0] irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mtimer_core #(.NUM_TIMERS(NT)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_req   (reg_req),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   localparam logic [11:0] A_CTRL = 12'h000, A_IE = 12'h100, A_IS = 12'h104, A_IT = 12'h108,
                           A_CFG = 12'h10C, A_CLO = 12'h110, A_CHI = 12'h114;

   function automatic logic [11:0] a_cmp(input int j, input int up);
      return 12'(12'h118 + 8 * j + 4 * up);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_req = 1'b0; reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
      reg_req = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cnt(input logic [31:0] hi, input logic [31:0] lo);
      wr(A_CLO, lo);
      wr(A_CHI, hi);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v2;
      logic [63:0] exp64;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R11 / R1 / R5: reset values
      chk("R11 irq after reset", 32'(irq), 32'h0);
      chk("R10 rdata idle", reg_rdata, 32'h0);
      rd(A_CTRL, v); chk("R11 ctrl reset", v, 32'h0);
      rd(A_IE, v);   chk("R11 enable reset", v, 32'h0);
      rd(A_IS, v);   chk("R11 status reset", v, 32'h0);
      rd(A_CLO, v);  chk("R11 counter reset", v, 32'h0);
      rd(A_CFG, v);  chk("R1 config reset step=1", v, 32'h0001_0000);
      for (int j = 0; j < NT; j++) begin
         rd(a_cmp(j, 0), v); chk("R5 compare lo reset", v, 32'hFFFF_FFFF);
         rd(a_cmp(j, 1), v); chk("R5 compare hi reset", v, 32'hFFFF_FFFF);
      end

      // R1 / R2 / R3: sweep prescale, step and window length
      for (int p = 0; p < 5; p++) begin
         for (int si = 0; si < 3; si++) begin
            for (int k = 1; k <= 7; k++) begin
               int s;
               s = (si == 0) ? 1 : (si == 1) ? 2 : 255;
               set_cnt(32'h0, 32'h0);
               wr(A_CFG, 32'((s << 16) | p));
               wr(A_CTRL, 32'h1);
               idle(k - 1);
               wr(A_CTRL, 32'h0);
               rd(A_CLO, v);
               chk("R1 R2 ticks times step", v, 32'(s * (k / (p + 1))));
            end
         end
      end
      rd(A_CFG, v); chk("R1 config fields readback", v, 32'h00FF_0004);

      // R3: inactive counter holds
      rd(A_CLO, v); idle(6); rd(A_CLO, v2);
      chk("R3 hold while inactive", v2, v);

      // R2: carry into upper word
      wr(A_CFG, 32'h0003_0000);
      set_cnt(32'h0, 32'hFFFF_FFFE);
      wr(A_CTRL, 32'h1);
      wr(A_CTRL, 32'h0);
      rd(A_CLO, v); chk("R2 carry lower", v, 32'h1);
      rd(A_CHI, v); chk("R2 carry upper", v, 32'h1);

      // R4: software write beats tick in the same cycle
      wr(A_CFG, 32'h0001_0000);
      set_cnt(32'h0, 32'h0);
      wr(A_CTRL, 32'h1);
      wr(A_CLO, 32'd100);
      wr(A_CTRL, 32'h0);
      rd(A_CLO, v); chk("R4 write wins then one tick", v, 32'd101);
      rd(A_CHI, v); chk("R4 upper untouched", v, 32'h0);

      // R5 / R6 / R8: expiry
      set_cnt(32'h0, 32'h0);
      wr(a_cmp(0, 0), 32'd10);
      wr(a_cmp(0, 1), 32'd0);
      rd(a_cmp(0, 0), v); chk("R5 compare lo readback", v, 32'd10);
      idle(1);
      rd(A_IS, v); chk("R6 below compare no status", v, 32'h0);
      wr(A_IE, 32'h1);
      wr(A_CLO, 32'd10);
      idle(1);
      rd(A_IS, v); chk("R6 equal sets status", v, 32'h1);
      chk("R8 irq0 enabled", 32'(irq), 32'h1);

      // R7: clear blocked while expired, effective after raising compare
      wr(A_IS, 32'h1);
      rd(A_IS, v); chk("R7 clear blocked while expired", v, 32'h1);
      wr(a_cmp(0, 0), 32'd20);
      wr(A_IS, 32'h1);
      rd(A_IS, v); chk("R7 clear after compare raised", v, 32'h0);
      chk("R8 irq0 dropped", 32'(irq), 32'h0);

      // R6: boundary one below and equal
      wr(A_CLO, 32'd19); idle(1);
      rd(A_IS, v); chk("R6 one below compare", v, 32'h0);
      wr(A_CLO, 32'd20); idle(1);
      rd(A_IS, v); chk("R6 equal to compare", v, 32'h1);
      wr(A_CLO, 32'd0); idle(1);
      wr(A_IS, 32'h1);
      rd(A_IS, v); chk("R7 cleared", v, 32'h0);

      // R6: upper word takes part in compare
      wr(a_cmp(0, 1), 32'h1);
      wr(a_cmp(0, 0), 32'h0);
      set_cnt(32'h0, 32'hFFFF_FFFF); idle(1);
      rd(A_IS, v); chk("R6 upper word below", v, 32'h0);
      wr(A_CLO, 32'h0);
      wr(A_CHI, 32'h1); idle(1);
      rd(A_IS, v); chk("R6 upper word equal", v, 32'h1);
      wr(A_CHI, 32'h0); idle(1);
      wr(A_IS, 32'h1);

      // R9 / R8: test injection and enable gating
      wr(A_IT, 32'h2);
      rd(A_IS, v); chk("R9 test sets status1", v, 32'h2);
      chk("R8 irq1 gated off", 32'(irq), 32'h0);
      rd(A_IT, v); chk("R9 test reads zero", v, 32'h0);
      wr(A_IE, 32'h3);
      chk("R8 irq1 enabled", 32'(irq), 32'h2);
      wr(A_IS, 32'h2);
      rd(A_IS, v); chk("R7 test bit cleared", v, 32'h0);
      chk("R8 irq none", 32'(irq), 32'h0);

      // R10: unmapped offsets and idle read data
      rd(12'h004, v); chk("R10 unmapped 0x004", v, 32'h0);
      rd(12'h0FC, v); chk("R10 unmapped 0x0FC", v, 32'h0);
      rd(12'h200, v); chk("R10 unmapped 0x200", v, 32'h0);
      rd(A_CFG, v); idle(1);
      chk("R10 rdata zero without read", reg_rdata, 32'h0);

      exp64 = 64'h0;
      rd(A_CHI, v); chk("R4 upper readback", v, exp64[63:32]);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule